// File: doc/BRIEF.md
# Feistel Round-Key Scheduler

This block supplies one round key per clock to a word-parametric Feistel round engine. It holds an n-bit master key as two n/2-bit halves, a left half and a right half. While the data path computes a round, the block computes the next key round beside it, so no keys are stored ahead of time. The block width N and the word width B are parameters, and each half carries NB = N/(2B) words. NB must be a multiple of three, because the substitution and the bit rotation act on groups of three words.

A round counter runs from 1 to NR. NR is odd, and H = floor(NR/2) marks the half-way point. Up to round H the round key is the right half. After the edge that leaves round H, the halves are exchanged once and the round key comes from the left half. The key round then uses a falling constant NR - i. Because of this, the engine that consumes the keys can derive its decryption keys with the same hardware. A start pulse loads the master key and restarts the counter at any time.

Top module: `sks_key_sched`

## Requirements
- R1: While reset is held and afterwards until the first start, valid_o, half_o, last_o and done_o are 0 and round_o is 0.
- R2: At the edge where start_i is 1, the left half is loaded from key_i[N-1:N/2] and the right half from key_i[N/2-1:0]. After that edge valid_o is 1, round_o is 1 and rkey_o equals key_i[N/2-1:0].
- R3: While valid_o is 1 and round_o is below NR, each clock raises round_o by one. last_o is 1 exactly while round_o equals NR.
- R4: The edge that leaves round NR clears valid_o and round_o and raises done_o for exactly one cycle.
- R5: On the edge that leaves a round i with i < H, the new left half is the old right half. The new right half is the old left half XOR F(old right half, i).
- R6: F(x,c) first adds c modulo 2^B to word 0 of x, which is bits [B-1:0]. No carry passes into word 1, and all other words pass unchanged.
- R7: F then applies the 3-bit substitution {0,5,6,7,4,3,1,2} bitwise to each group of words (3g, 3g+1, 3g+2). The input value for bit j is {w3g+2[j], w3g+1[j], w3g[j]}, and the output bits are placed back in the same order.
- R8: F then rotates word 3g right by one bit, keeps word 3g+1 as it is and rotates word 3g+2 left by one bit. Finally it moves every word k to position (k+1) mod NB.
- R9: The edge that leaves round H only exchanges the two halves. The key for round H+1 therefore equals the key for round H, and half_o is 1 from round H+1 to round NR.
- R10: On the edge that leaves a round i with H < i < NR, the same key round as in R5 is applied, but with the constant NR - i. While half_o is 1, rkey_o shows the left half.
- R11: A start pulse during a run discards the run in progress and behaves exactly as in R2 with the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load master key and restart at round 1 |
| key_i | input | N | Master key |
| rkey_o | output | N/2 | Round key for the current round |
| valid_o | output | 1 | A round is in progress |
| round_o | output | $clog2(NR+1) | Current round index, 0 when idle |
| half_o | output | 1 | Second half of execution, key taken from the left half |
| last_o | output | 1 | Current round is round NR |
| done_o | output | 1 | One-cycle pulse after round NR |

## Verification
The first round key appears at the same edge that samples start_i. Round r is therefore shown in the r-th cycle after the start edge, and done_o is due one cycle after round NR. The bench drives inputs on the falling edge and samples every output on the following falling edge, so each check reads the value settled by exactly one rising edge. A bench model steps the two key halves once per sampled round, and starts that are issued in the middle of a run realign the model at the same edge.

// File: rtl/sks_pkg.sv
package sks_pkg;

    function automatic logic [2:0] sks_sub3(input logic [2:0] v);
        logic [2:0] o;
        case (v)
            3'd0: o = 3'd0;
            3'd1: o = 3'd5;
            3'd2: o = 3'd6;
            3'd3: o = 3'd7;
            3'd4: o = 3'd4;
            3'd5: o = 3'd3;
            3'd6: o = 3'd1;
            default: o = 3'd2;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sks_sbox_layer.sv
module sks_sbox_layer #(
    parameter int B  = 8,
    parameter int NB = 6
) (
    input  logic [NB*B-1:0] in_i,
    output logic [NB*B-1:0] out_o
);
    localparam int NG = NB / 3;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar j = 0; j < B; j++) begin : g_bit
            logic [2:0] v;
            logic [2:0] o;
            assign v = {in_i[(3*g+2)*B+j], in_i[(3*g+1)*B+j], in_i[(3*g)*B+j]};
            assign o = sks_pkg::sks_sub3(v);
            assign out_o[(3*g)*B+j]   = o[0];
            assign out_o[(3*g+1)*B+j] = o[1];
            assign out_o[(3*g+2)*B+j] = o[2];
        end
    end
endmodule

// File: rtl/sks_rotate.sv
module sks_rotate #(
    parameter int B  = 8,
    parameter int NB = 6
) (
    input  logic [NB*B-1:0] in_i,
    output logic [NB*B-1:0] out_o
);
    localparam int NG = NB / 3;

    logic [NB*B-1:0] br;

    for (genvar g = 0; g < NG; g++) begin : g_bitrot
        assign br[(3*g)*B +: B]   = {in_i[(3*g)*B], in_i[(3*g)*B+1 +: B-1]};
        assign br[(3*g+1)*B +: B] = in_i[(3*g+1)*B +: B];
        assign br[(3*g+2)*B +: B] = {in_i[(3*g+2)*B +: B-1], in_i[(3*g+2)*B+B-1]};
    end

    for (genvar k = 0; k < NB; k++) begin : g_wordrot
        assign out_o[((k+1)%NB)*B +: B] = br[k*B +: B];
    end
endmodule

// File: rtl/sks_key_round.sv
module sks_key_round #(
    parameter int B  = 8,
    parameter int NB = 6
) (
    input  logic [NB*B-1:0] src_i,
    input  logic [NB*B-1:0] mix_i,
    input  logic [B-1:0]    const_i,
    output logic [NB*B-1:0] out_o
);
    logic [NB*B-1:0] added;
    logic [NB*B-1:0] subst;
    logic [NB*B-1:0] rotd;

    // single adder on word 0 only; the constant never needs more than B bits
    assign added[B-1:0] = src_i[B-1:0] + const_i;
    if (NB > 1) begin : g_upper
        assign added[NB*B-1:B] = src_i[NB*B-1:B];
    end

    sks_sbox_layer #(.B(B), .NB(NB)) u_sbox (.in_i(added), .out_o(subst));
    sks_rotate     #(.B(B), .NB(NB)) u_rot  (.in_i(subst), .out_o(rotd));

    assign out_o = mix_i ^ rotd;
endmodule

// File: rtl/sks_ctrl.sv
module sks_ctrl #(
    parameter int NR = 93,
    parameter int RW = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic [RW-1:0] round_o,
    output logic          valid_o,
    output logic          half_o,
    output logic          last_o,
    output logic          switch_o,
    output logic          done_o
);
    localparam logic [RW-1:0] NR_W = RW'(NR);
    localparam logic [RW-1:0] H_W  = RW'(NR / 2);

    typedef struct packed {
        logic          busy;
        logic [RW-1:0] rnd;
        logic          done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.rnd  = RW'(1);
        end else if (s_q.busy) begin
            if (s_q.rnd == NR_W) begin
                s_d.busy = 1'b0;
                s_d.rnd  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.rnd = s_q.rnd + RW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign round_o  = s_q.rnd;
    assign valid_o  = s_q.busy;
    assign half_o   = s_q.busy && (s_q.rnd > H_W);
    assign last_o   = s_q.busy && (s_q.rnd == NR_W);
    assign switch_o = s_q.busy && (s_q.rnd == H_W);
    assign done_o   = s_q.done;

    a_r2_start_round1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (valid_o && round_o == RW'(1)));
    a_r3_round_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !last_o && !start_i) |=> (valid_o && round_o == $past(round_o) + RW'(1)));
    a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_o && !start_i) |=> (done_o && !valid_o));
    a_r9_half_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(half_o) |-> (round_o == H_W + RW'(1)));
endmodule

// File: rtl/sks_key_sched.sv
module sks_key_sched #(
    parameter int N  = 96,
    parameter int B  = 8,
    parameter int NR = 93,
    localparam int HW = N / 2,
    localparam int NB = HW / B,
    localparam int RW = $clog2(NR + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [N-1:0]  key_i,
    output logic [HW-1:0] rkey_o,
    output logic          valid_o,
    output logic [RW-1:0] round_o,
    output logic          half_o,
    output logic          last_o,
    output logic          done_o
);
    localparam logic [RW-1:0] NR_W = RW'(NR);
    localparam logic [RW-1:0] H_W  = RW'(NR / 2);

    initial begin
        assert (NB % 3 == 0 && NB * B == HW) else $error("half width must be 3k words");
        assert (NR % 2 == 1) else $error("round count must be odd");
        assert ((NR / 2) < (1 << B)) else $error("constant exceeds one word");
    end

    typedef struct packed {
        logic [HW-1:0] kl;
        logic [HW-1:0] kr;
    } keys_t;

    keys_t k_d, k_q;

    logic          sw;
    logic [RW-1:0] cidx;
    logic [HW-1:0] kr_new;

    sks_ctrl #(.NR(NR), .RW(RW)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .round_o (round_o),
        .valid_o (valid_o),
        .half_o  (half_o),
        .last_o  (last_o),
        .switch_o(sw),
        .done_o  (done_o)
    );

    // rising constant before the switch, falling constant after it
    assign cidx = (round_o < H_W) ? round_o : (NR_W - round_o);

    sks_key_round #(.B(B), .NB(NB)) u_kround (
        .src_i  (k_q.kr),
        .mix_i  (k_q.kl),
        .const_i(B'(cidx)),
        .out_o  (kr_new)
    );

    always_comb begin
        k_d = k_q;
        if (start_i) begin
            k_d.kl = key_i[N-1:HW];
            k_d.kr = key_i[HW-1:0];
        end else if (valid_o && !last_o) begin
            if (sw) begin
                k_d.kl = k_q.kr;
                k_d.kr = k_q.kl;
            end else begin
                k_d.kl = k_q.kr;
                k_d.kr = kr_new;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) k_q <= '0;
        else         k_q <= k_d;
    end

    assign rkey_o = half_o ? k_q.kl : k_q.kr;

    a_r2_key_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (rkey_o == $past(key_i[HW-1:0])));
    a_r9_switch_key_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && round_o == H_W && !start_i) |=> (half_o && rkey_o == $past(rkey_o)));
    a_r5_left_from_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !last_o && !start_i && round_o != H_W) |=> (k_q.kl == $past(k_q.kr)));
    a_r10_key_from_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_o |-> (rkey_o == k_q.kl));
endmodule

// File: tb/sks_key_sched_test.sv
module sks_key_sched_test;
    localparam int N  = 96;
    localparam int HW = 48;
    localparam int NR = 93;
    localparam int H  = NR / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [N-1:0]  key;
    logic [HW-1:0] rkey;
    logic          valid, half, last, done;
    logic [6:0]    round;

    int checks = 0;
    int errors = 0;
    bit restart_pending = 0;

    sks_key_sched #(.N(N), .B(8), .NR(NR)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
        .rkey_o(rkey), .valid_o(valid), .round_o(round),
        .half_o(half), .last_o(last), .done_o(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] sub(input logic [2:0] v);
        logic [2:0] tbl [8] = '{3'd0, 3'd5, 3'd6, 3'd7, 3'd4, 3'd3, 3'd1, 3'd2};
        return tbl[v];
    endfunction

    // R6 adder, R7 substitution, R8 rotations
    function automatic logic [HW-1:0] fmix(input logic [HW-1:0] x, input logic [7:0] c);
        logic [HW-1:0] y, s, t, u;
        logic [2:0] v, o;
        logic [7:0] w;
        y = x;
        y[7:0] = x[7:0] + c;
        for (int g = 0; g < 2; g++) begin
            for (int j = 0; j < 8; j++) begin
                v = {y[(3*g+2)*8+j], y[(3*g+1)*8+j], y[(3*g)*8+j]};
                o = sub(v);
                s[(3*g)*8+j]   = o[0];
                s[(3*g+1)*8+j] = o[1];
                s[(3*g+2)*8+j] = o[2];
            end
        end
        t = s;
        for (int g = 0; g < 2; g++) begin
            w = s[(3*g)*8 +: 8];
            t[(3*g)*8 +: 8] = {w[0], w[7:1]};
            w = s[(3*g+2)*8 +: 8];
            t[(3*g+2)*8 +: 8] = {w[6:0], w[7]};
        end
        for (int k = 0; k < 6; k++) u[((k+1)%6)*8 +: 8] = t[k*8 +: 8];
        return u;
    endfunction

    task automatic run(input logic [N-1:0] k, input int stop_at);
        logic [HW-1:0] kl, kr, nk, exp;
        start = 1'b1;
        key = k;
        kl = k[N-1:HW];
        kr = k[HW-1:0];
        @(negedge clk);
        start = 1'b0;
        for (int r = 1; r <= NR; r++) begin
            exp = (r > H) ? kl : kr;
            if (r == 1) begin
                chk(valid && round == 7'd1 && rkey == exp,
                    restart_pending ? "R11 restart load" : "R2 load", rkey, exp);
                restart_pending = 0;
            end else if (r <= H) begin
                chk(rkey == exp, "R5 R6 R7 R8 first-half key", rkey, exp);
            end else if (r == H + 1) begin
                chk(rkey == exp && half, "R9 switch key", rkey, exp);
            end else begin
                chk(rkey == exp, "R10 second-half key", rkey, exp);
            end
            chk(valid && round == 7'(r) && last == (r == NR), "R3 counter",
                {41'd0, round}, 48'(r));
            chk(half == (r > H), "R9 half flag", {47'd0, half}, {47'd0, r > H});
            if (r == stop_at) begin
                restart_pending = 1;
                return;
            end
            if (r == H) begin
                nk = kl; kl = kr; kr = nk;
            end else if (r < NR) begin
                nk = kl ^ fmix(kr, (r < H) ? 8'(r) : 8'(NR - r));
                kl = kr;
                kr = nk;
            end
            @(negedge clk);
        end
        chk(done && !valid && round == 7'd0, "R4 done pulse", {46'd0, done, valid}, 48'd2);
        @(negedge clk);
        chk(!done && !valid, "R4 done one cycle", {46'd0, done, valid}, 48'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        start = 1'b0;
        key   = '0;
        repeat (3) @(negedge clk);
        chk(!valid && !half && !last && !done && round == 7'd0, "R1 reset state",
            {41'd0, round}, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid && !done && round == 7'd0, "R1 idle after reset", {41'd0, round}, 48'd0);
        run('0, 0);
        run({48'h0, 48'hFFFF_FFFF_FFFF}, 0);
        run({48'hA5A5_0F0F_C3C3, 48'h0123_4567_89FF}, 0);
        for (int i = 0; i < 5; i++) begin
            run({$urandom(), $urandom(), $urandom()}, 0);
        end
        run({$urandom(), $urandom(), $urandom()}, 10);
        run({$urandom(), $urandom(), $urandom()}, H + 3);
        run({$urandom(), $urandom(), $urandom()}, NR);
        run({$urandom(), $urandom(), $urandom()}, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule